// File: doc/BRIEF.md
# Decimal Numeral Recognizer

This block reads a stream of 8-bit ASCII characters, one per clock edge on which the valid strobe is high. It decides whether the stream spells a decimal floating-point numeral. Blanks may come first. An optional sign follows, then digits. A decimal point may introduce a fractional run, and a lowercase exponent marker may introduce an exponent digit run. A blank after the integer, fraction or exponent part ends the numeral.

The recognizer keeps one of seven states in a 3-bit register, and that register is visible on an output port. It raises a completion flag once a numeral has been terminated, and a fault flag once the stream can no longer form one. Both conditions last until reset. A host clears the block with the synchronous reset, streams a candidate string, and reads the flags.

Each character is first sorted into a small class: blank, digit, sign, point, exponent marker or other. The next state is then looked up from the current state and that class.

Top module: `numeral_recognizer`

## Requirements
- R1: The state output uses the codes start=000, sign=001, whole=010, frac=011, exp=100, done=101, error=110, and never shows 111. Synchronous reset forces start, with ok and err low, even in the middle of a string.
- R2: From start, a blank (space 0x20 or tab 0x09) stays in start. A digit '0'..'9' moves to whole, '+' or '-' moves to sign, and '.' moves to frac.
- R3: From sign, a digit moves to whole and '.' moves to frac.
- R4: From whole, a digit stays in whole, '.' moves to frac, lowercase 'e' (0x65) moves to exp, and a blank moves to done.
- R5: From frac, a digit stays in frac, 'e' moves to exp, and a blank moves to done.
- R6: From exp, a digit stays in exp and a blank moves to done.
- R7: A character with no transition listed in R2 to R6 for the current state moves the machine to error. This includes an uppercase 'E', a second sign and a second point.
- R8: done and error are absorbing: any further valid character leaves the state unchanged.
- R9: On a clock edge where valid is low, the state does not change, whatever the character input carries.
- R10: ok is high exactly while the state is done, err is high exactly while the state is error, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, returns to start |
| in_valid | input | 1 | High when in_char carries a character to consume |
| in_char | input | CHAR_W (8) | ASCII character |
| state_o | output | 3 | Current recognizer state code |
| ok | output | 1 | A complete numeral has been recognized |
| err | output | 1 | The stream can no longer form a numeral |

## Verification
A table of strings is driven through the block. It includes plain integers, a signed number with fraction and exponent, leading spaces and tabs, a bare point followed by a fraction, and the degenerate "+.e " that the table still accepts. After every character the state is compared with a separately written model, so a wrong arrow shows up at the exact state where it leaves. Strings with a doubled point, a doubled sign, a letter, an uppercase exponent or a leading 'e' separate the fault path from the legal ones. A string cut short inside the exponent shows that neither flag rises early. Directed tests stall the strobe while junk sits on the character input, feed characters after done and after error, and reset in mid-string.

// File: rtl/numrec_pkg.sv
package numrec_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'b000,
    ST_SIGN  = 3'b001,
    ST_WHOLE = 3'b010,
    ST_FRAC  = 3'b011,
    ST_EXPO  = 3'b100,
    ST_DONE  = 3'b101,
    ST_FAIL  = 3'b110
  } scan_st_e;

  typedef enum logic [2:0] {
    CC_BLANK   = 3'd0,
    CC_DIGIT   = 3'd1,
    CC_SIGN    = 3'd2,
    CC_POINT   = 3'd3,
    CC_EXPMARK = 3'd4,
    CC_OTHER   = 3'd5
  } cls_e;

  // Sort one ASCII byte into the class the transition table is keyed on.
  function automatic cls_e char_class(logic [7:0] c);
    cls_e k;
    if (c == 8'h20 || c == 8'h09)        k = CC_BLANK;
    else if (c >= 8'h30 && c <= 8'h39)   k = CC_DIGIT;
    else if (c == 8'h2B || c == 8'h2D)   k = CC_SIGN;
    else if (c == 8'h2E)                 k = CC_POINT;
    else if (c == 8'h65)                 k = CC_EXPMARK;
    else                                 k = CC_OTHER;
    return k;
  endfunction

  // Transition table: current state and character class give the next state.
  function automatic scan_st_e advance(scan_st_e s, cls_e k);
    scan_st_e n;
    n = ST_FAIL;
    case (s)
      ST_START: case (k)
        CC_BLANK: n = ST_START;
        CC_DIGIT: n = ST_WHOLE;
        CC_SIGN:  n = ST_SIGN;
        CC_POINT: n = ST_FRAC;
        default:  n = ST_FAIL;
      endcase
      ST_SIGN: case (k)
        CC_DIGIT: n = ST_WHOLE;
        CC_POINT: n = ST_FRAC;
        default:  n = ST_FAIL;
      endcase
      ST_WHOLE: case (k)
        CC_DIGIT:   n = ST_WHOLE;
        CC_POINT:   n = ST_FRAC;
        CC_EXPMARK: n = ST_EXPO;
        CC_BLANK:   n = ST_DONE;
        default:    n = ST_FAIL;
      endcase
      ST_FRAC: case (k)
        CC_DIGIT:   n = ST_FRAC;
        CC_EXPMARK: n = ST_EXPO;
        CC_BLANK:   n = ST_DONE;
        default:    n = ST_FAIL;
      endcase
      ST_EXPO: case (k)
        CC_DIGIT: n = ST_EXPO;
        CC_BLANK: n = ST_DONE;
        default:  n = ST_FAIL;
      endcase
      ST_DONE: n = ST_DONE;
      default: n = ST_FAIL;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/numrec_classify.sv
module numrec_classify
  import numrec_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] ch,
  output cls_e              cls
);
  generate
    if (CHAR_W > 8) begin : g_wide
      // Code points above one byte are never part of a numeral.
      assign cls = (|ch[CHAR_W-1:8]) ? CC_OTHER : char_class(ch[7:0]);
    end else begin : g_byte
      assign cls = char_class(ch[7:0]);
    end
  endgenerate
endmodule

// File: rtl/numrec_step.sv
module numrec_step
  import numrec_pkg::*;
(
  input  scan_st_e cur,
  input  cls_e     cls,
  output scan_st_e nxt,
  output logic     to_fail,
  output logic     to_done
);
  always_comb begin
    nxt     = advance(cur, cls);
    to_fail = (nxt == ST_FAIL) && (cur != ST_FAIL);
    to_done = (nxt == ST_DONE) && (cur != ST_DONE);
  end
endmodule

// File: rtl/numeral_recognizer.sv
module numeral_recognizer
  import numrec_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic [2:0]        state_o,
  output logic              ok,
  output logic              err
);
  scan_st_e state_q;
  scan_st_e state_d;
  cls_e     char_cls;
  logic     step;
  logic     ev_fail;
  logic     ev_done;

  numrec_classify #(.CHAR_W(CHAR_W)) u_cls (
    .ch  (in_char),
    .cls (char_cls)
  );

  numrec_step u_step (
    .cur     (state_q),
    .cls     (char_cls),
    .nxt     (state_d),
    .to_fail (ev_fail),
    .to_done (ev_done)
  );

  assign step = in_valid;

  always_ff @(posedge clk) begin
    if (rst)       state_q <= ST_START;
    else if (step) state_q <= state_d;
  end

  assign state_o = state_q;
  assign ok      = (state_q == ST_DONE);
  assign err     = (state_q == ST_FAIL);
endmodule

// File: rtl/numrec_checker.sv
module numrec_checker
  import numrec_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_char,
  input logic [2:0] state,
  input logic       ok,
  input logic       err,
  input logic       ev_fail,
  input logic       ev_done
);
  logic is_digit;
  assign is_digit = (in_char >= 8'h30) && (in_char <= 8'h39);

  AST_ENC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state != 3'b111); // R1

  AST_START_DIGIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state == ST_START && is_digit) |=> state == ST_WHOLE); // R2

  AST_SIGN_POINT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state == ST_SIGN && in_char == 8'h2E) |=> state == ST_FRAC); // R3

  AST_WHOLE_EXP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state == ST_WHOLE && in_char == 8'h65) |=> state == ST_EXPO); // R4

  AST_FRAC_POINT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state == ST_FRAC && in_char == 8'h2E) |=> state == ST_FAIL); // R7

  AST_FAIL_EVENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_fail) |=> err); // R7

  AST_DONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_done) |=> ok); // R10

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> state == ST_DONE); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAIL) |=> state == ST_FAIL); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state)); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ok && err)); // R10
endmodule

bind numeral_recognizer numrec_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_char  (in_char[7:0]),
  .state    (state_o),
  .ok       (ok),
  .err      (err),
  .ev_fail  (ev_fail),
  .ev_done  (ev_done)
);

// File: tb/numeral_recognizer_bench.sv
module numeral_recognizer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic [2:0] state_o;
  logic       ok;
  logic       err;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  numeral_recognizer u_numeral_recognizer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .state_o(state_o), .ok(ok), .err(err)
  );

  localparam int NV = 15;
  localparam logic [63:0] VEC_STR [NV] = '{
    "123 ", "-1.5e10 ", "+.e ", "  42 ", "1.2.3", "12x", "+-1", "3e",
    ".5 ", "1e5 9", "e1", "7E3 ", "\t-8 ", "-", "-.5 "};
  localparam int VEC_LEN [NV] = '{4, 8, 4, 5, 5, 3, 3, 2, 3, 5, 2, 4, 4, 1, 4};
  localparam logic [2:0] VEC_END [NV] = '{
    3'd5, 3'd5, 3'd5, 3'd5, 3'd6, 3'd6, 3'd6, 3'd4,
    3'd5, 3'd5, 3'd6, 3'd6, 3'd5, 3'd1, 3'd5};

  // Independent model of the requirement table, written per character.
  function automatic logic [2:0] ref_next(logic [2:0] s, logic [7:0] c);
    logic dig, blk;
    dig = (c >= "0") && (c <= "9");
    blk = (c == " ") || (c == 8'h09);
    if (s == 3'd5 || s == 3'd6) return s;
    if (s == 3'd0) begin
      if (blk) return 3'd0;
      if (dig) return 3'd2;
      if (c == "+" || c == "-") return 3'd1;
      if (c == ".") return 3'd3;
    end else if (s == 3'd1) begin
      if (dig) return 3'd2;
      if (c == ".") return 3'd3;
    end else if (s == 3'd2) begin
      if (dig) return 3'd2;
      if (c == ".") return 3'd3;
      if (c == "e") return 3'd4;
      if (blk) return 3'd5;
    end else if (s == 3'd3) begin
      if (dig) return 3'd3;
      if (c == "e") return 3'd4;
      if (blk) return 3'd5;
    end else if (s == 3'd4) begin
      if (dig) return 3'd4;
      if (blk) return 3'd5;
    end
    return 3'd6;
  endfunction

  function automatic string req_of(logic [2:0] prev, logic [2:0] nxt);
    if (prev == 3'd5 || prev == 3'd6) return "R8";
    if (nxt == 3'd6) return "R7";
    case (prev)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one valid character for one edge, then sample after that edge.
  task automatic send(logic [7:0] c);
    in_valid = 1'b1; in_char = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] model;
    logic [2:0] prev;
    logic [7:0] c;

    do_reset();
    check("R1", "reset state", state_o, 0);
    check("R1", "reset ok", ok, 0);
    check("R1", "reset err", err, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      model = 3'd0;
      for (int i = 0; i < VEC_LEN[v]; i++) begin
        c = VEC_STR[v][8*(VEC_LEN[v]-1-i) +: 8];
        send(c);
        prev  = model;
        model = ref_next(model, c);
        check(req_of(prev, model), $sformatf("vec %0d char %0d state", v, i),
              state_o, model);
      end
      check("R10", $sformatf("vec %0d final state", v), state_o, VEC_END[v]);
      check("R10", $sformatf("vec %0d ok", v), ok, VEC_END[v] == 3'd5);
      check("R10", $sformatf("vec %0d err", v), err, VEC_END[v] == 3'd6);
    end

    // R9: strobe low with junk on the character input holds the state
    do_reset();
    send("4");
    check("R4", "digit into whole", state_o, 2);
    in_char = "x";
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R9", "hold with valid low", state_o, 2);
    in_char = " ";
    @(negedge clk);
    check("R9", "blank with valid low ignored", state_o, 2);
    send(" ");
    check("R10", "done raises ok", ok, 1);
    send("x");
    check("R8", "done absorbs junk", state_o, 5);

    // R7 / R8: fault path is absorbing
    do_reset();
    send("?");
    check("R7", "junk from start", state_o, 6);
    check("R10", "err flag", err, 1);
    send("1");
    send(" ");
    check("R8", "error absorbs digit and blank", state_o, 6);

    // R6: exponent digits stay in exp
    do_reset();
    send("2"); send("e"); send("7"); send("7");
    check("R6", "exp digits", state_o, 4);

    // R1: reset in mid-string
    do_reset();
    send("5"); send(".");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "mid-string reset", state_o, 0);
    check("R1", "mid-string reset flags", {ok, err}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule